// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Gate

This block copies one reference clock onto eighteen outputs and lets a two-wire serial host switch each copy on or off. The host programs the block with a write-only frame on a standard-mode I2C bus (SCL up to 100 kHz). The block acts only as a target and only receives. A faster system clock samples both bus lines through synchronizers and a short glitch filter. The block finds START and STOP conditions, checks a fixed 7-bit address, and acknowledges bytes by asserting an open-drain pull-down enable on SDA.

A frame holds the address byte, then two header bytes (a command and a byte count) that are acknowledged and thrown away, then up to three data bytes. The data bytes load the enable registers in a fixed order, and no register can be chosen by address. Each data byte takes effect at its own acknowledge, so a frame that stops early leaves the remaining registers as they were. An output with its enable set follows the reference clock. An output with its enable cleared is held low. A global output-enable input that is low takes every output out of drive.

Output numbering: outputs 0..3 form group 1, 4..7 group 2, 8..11 group 3, 12..15 group 4, and 16 and 17 are the two feedback outputs.

Top module: `clkfan_i2c_gate`

## Requirements
- R1: After reset every enable bit is 1: with `out_en` high, all 18 outputs follow `clk_src` and all drive enables are 1.
- R2: Only the address byte 0xD2 (7-bit address 1101001 with R/W = 0) is acknowledged. For any other address, or R/W = 1, SDA is left released for that byte and for every later byte until the next STOP or START.
- R3: In a matched frame the second byte (command) and the third byte (count) are acknowledged and change no output, whatever their values.
- R4: The data bytes fill the registers in order. Data byte 0 bits 3..0 enable outputs 0..3 and bits 7..4 enable outputs 4..7. Data byte 1 bits 3..0 enable outputs 8..11 and bits 7..4 enable outputs 12..15. Data byte 2 bit 6 enables output 16 and bit 7 enables output 17. Bits 5..0 of data byte 2 are reserved and control nothing.
- R5: An output whose enable bit is 0 stays low whatever `clk_src` does. An output whose enable bit is 1 equals `clk_src`.
- R6: While `out_en` is low, every bit of `fan_drive` is 0 and every bit of `fan_o` is 0, whatever the register contents or `clk_src`.
- R7: Bytes after data byte 2 are acknowledged and change no output.
- R8: Each data byte takes effect at its own acknowledge. A frame that ends after fewer data bytes leaves the registers it did not reach unchanged.
- R9: A STOP or a START at any point ends the current frame. After a START, the next byte is treated as an address byte.
- R10: A pulse on SDA lasting one system clock while SCL is high is not taken as a START or STOP, and the frame it falls in completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| clk_src | input | 1 | Reference clock to be fanned out |
| out_en | input | 1 | Global output enable; low removes drive from all outputs |
| fan_o | output | 18 | Gated copies of the reference clock |
| fan_drive | output | 18 | Per-output pad drive enable; 0 means high impedance |

## Verification
On every cycle the assertions check the following. No disabled output ever carries a high level. The drive enables drop when the global enable is low. SDA is pulled only in the acknowledge state, and the pull begins only while SCL is low. A STOP always sends the receiver back to idle. At most one register is written per cycle, and the registers hold when no write is issued. The sequence of bytes across a frame can only be shown by the bench scenarios. These cover header bytes that are discarded, data bytes that land in order, trailing bytes, frames cut short, a START in mid-frame, wrong addresses and reads, and a filtered glitch. The bench compares each of these against its own byte-level model of the acknowledge pattern and register contents.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_ACK  = 2'd2,
    ST_IGN  = 2'd3
  } rx_state_t;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HDR_CNT = 3;  // address, command, count
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned NLINE = 2,
  parameter int unsigned SYNC  = 2,
  parameter int unsigned FILT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] line_i,
  output logic [NLINE-1:0] line_o
);
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [SYNC-1:0] sync_q;
    logic [FILT-1:0] hist_q;
    logic            out_q;
    logic            out_n;

    always_comb begin
      out_n = out_q;
      if (&hist_q)       out_n = 1'b1;
      else if (~|hist_q) out_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], line_i[g]};
        hist_q <= {hist_q[FILT-2:0], sync_q[SYNC-1]};
        out_q  <= out_n;
      end
    end

    assign line_o[g] = out_q;
  end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  ADDR = 7'h69,
  parameter int unsigned NDAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_pull,
  output logic [NDAT-1:0]   commit,
  output logic [BYTE_W-1:0] wdata
);
  localparam int unsigned IDX_MAX = HDR_CNT + NDAT;
  localparam int unsigned IW      = $clog2(IDX_MAX + 1);

  rx_state_t         st_q, st_n;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic              pull_q, pull_n;
  logic [NDAT-1:0]   com_q, com_n;
  logic              scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    pull_n = pull_q;
    com_n  = '0;
    if (start_c) begin
      st_n   = ST_RX;
      cnt_n  = '0;
      idx_n  = '0;
      pull_n = 1'b0;
    end else if (stop_c) begin
      st_n   = ST_IDLE;
      pull_n = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (idx_q == '0 && sh_q != {ADDR, 1'b0}) begin
              st_n = ST_IGN;
            end else begin
              st_n   = ST_ACK;
              pull_n = 1'b1;
              for (int k = 0; k < NDAT; k++)
                if (idx_q == IW'(HDR_CNT + k)) com_n[k] = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            pull_n = 1'b0;
            cnt_n  = '0;
            st_n   = ST_RX;
            if (idx_q != IW'(IDX_MAX)) idx_n = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      pull_q <= 1'b0;
      com_q  <= '0;
    end else begin
      st_q   <= st_n;
      scl_q  <= scl;
      sda_q  <= sda;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      pull_q <= pull_n;
      com_q  <= com_n;
    end
  end

  assign sda_pull = pull_q;
  assign commit   = com_q;
  assign wdata    = sh_q;

  // R2: SDA is pulled only while acknowledging a matched frame
  a_r2_pull_only_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_IGN) |-> !pull_q);
  // R2: the pull starts only while SCL is low
  a_r2_pull_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl);
  // R9: a STOP returns the receiver to idle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st_q == ST_IDLE && !pull_q));
  // R7: byte index saturates after the last data byte
  a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(IDX_MAX));
  // R4: at most one register is written per cycle
  a_r4_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_q));
endmodule

// File: rtl/enable_regs.sv
module enable_regs
  import clkfan_pkg::*;
#(
  parameter int unsigned NDAT = 3,
  parameter int unsigned FB_W = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NDAT-1:0]                       commit,
  input  logic [BYTE_W-1:0]                     wdata,
  output logic [(NDAT-1)*BYTE_W+FB_W-1:0]       en_o
);
  localparam int unsigned FULL = NDAT - 1;
  localparam int unsigned NOUT = FULL * BYTE_W + FB_W;

  for (genvar k = 0; k < FULL; k++) begin : g_full
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         r_q <= '1;
      else if (commit[k]) r_q <= wdata;
    end
    assign en_o[k*BYTE_W +: BYTE_W] = r_q;
  end

  // last register: only its top FB_W bits steer outputs
  logic [FB_W-1:0] fb_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            fb_q <= '1;
    else if (commit[FULL]) fb_q <= wdata[BYTE_W-1 -: FB_W];
  end
  assign en_o[NOUT-1 -: FB_W] = fb_q;

  // R8: enables hold when no byte is committed
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (commit == '0) |=> $stable(en_o));
endmodule

// File: rtl/fan_gate.sv
module fan_gate #(
  parameter int unsigned NOUT = 18
) (
  input  logic            clk_src,
  input  logic            out_en,
  input  logic [NOUT-1:0] en,
  output logic [NOUT-1:0] fan_o,
  output logic [NOUT-1:0] fan_drive
);
  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign fan_o[i]     = out_en & en[i] & clk_src;
    assign fan_drive[i] = out_en;
  end
endmodule

// File: rtl/clkfan_i2c_gate.sv
module clkfan_i2c_gate
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  ADDR = 7'h69,
  parameter int unsigned SYNC = 2,
  parameter int unsigned FILT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  input  logic        clk_src,
  input  logic        out_en,
  output logic [17:0] fan_o,
  output logic [17:0] fan_drive
);
  localparam int unsigned NDAT = 3;
  localparam int unsigned FB_W = 2;
  localparam int unsigned NOUT = (NDAT - 1) * BYTE_W + FB_W;

  logic [1:0]        line_f;
  logic [NDAT-1:0]   commit;
  logic [BYTE_W-1:0] wdata;
  logic [NOUT-1:0]   en_vec;

  i2c_line_sync #(.NLINE(2), .SYNC(SYNC), .FILT(FILT)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i({sda_i, scl_i}), .line_o(line_f));

  i2c_wr_target #(.ADDR(ADDR), .NDAT(NDAT)) u_tgt (
    .clk(clk), .rst_n(rst_n), .scl(line_f[0]), .sda(line_f[1]),
    .sda_pull(sda_pull), .commit(commit), .wdata(wdata));

  enable_regs #(.NDAT(NDAT), .FB_W(FB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wdata(wdata), .en_o(en_vec));

  fan_gate #(.NOUT(NOUT)) u_gate (
    .clk_src(clk_src), .out_en(out_en), .en(en_vec),
    .fan_o(fan_o), .fan_drive(fan_drive));

  // R5: no disabled output carries a high level
  a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_o & ~en_vec) == '0);
  // R6: global enable low removes all drive
  a_r6_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (fan_drive == '0 && fan_o == '0));
endmodule

// File: tb/clkfan_i2c_gate_bench.sv
module clkfan_i2c_gate_bench;
  localparam time CLK_P = 10ns;
  localparam int  Q     = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1, sda_drv = 1'b1;
  logic        clk_src = 1'b0, out_en = 1'b1;
  logic        sda_pull;
  logic [17:0] fan_o, fan_drive;
  wire         sda_line = sda_drv & ~sda_pull;

  int errors = 0, checks = 0;
  bit cmp_on = 1'b0, hold_src = 1'b0;
  logic [7:0] exp_reg [3];
  int  mdl_idx = 0;
  bit  mdl_match = 1'b0;

  clkfan_i2c_gate u_clkfan_i2c_gate (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull(sda_pull), .clk_src(clk_src), .out_en(out_en),
    .fan_o(fan_o), .fan_drive(fan_drive));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [17:0] exp_en();
    return {exp_reg[2][7:6], exp_reg[1], exp_reg[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  // reference clock pattern, changed away from the sampling edge
  initial begin
    int s = 7;
    forever begin
      @(posedge clk); #(CLK_P/4);
      s = (s * 13 + 5) % 97;
      clk_src = hold_src ? 1'b1 : s[2];
    end
  end

  // per-cycle comparison against the model while the bus is idle
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [17:0] ef, ed;
      ef = {18{out_en & clk_src}} & exp_en();
      ed = {18{out_en}};
      chk(fan_o == ef, "R5", "fan_o per cycle", 32'(fan_o), 32'(ef));
      chk(fan_drive == ed, "R6", "fan_drive per cycle", 32'(fan_drive), 32'(ed));
      chk(!sda_pull, "R2", "sda idle", 32'(sda_pull), 32'd0);
    end
  end

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    cmp_on = 1'b0;
    sda_drv = 1'b1; wait_c(Q);
    scl_drv = 1'b1; wait_c(Q);
    sda_drv = 1'b0; wait_c(Q);
    scl_drv = 1'b0; wait_c(Q);
    mdl_idx = 0;
    mdl_match = 1'b0;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_c(Q);
    scl_drv = 1'b1; wait_c(Q);
    sda_drv = 1'b1; wait_c(2*Q);
    cmp_on = 1'b1;
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_drv = b; wait_c(Q);
    scl_drv = 1'b1;
    if (glitch) begin
      wait_c(Q/2); sda_drv = 1'b0; wait_c(1); sda_drv = 1'b1;
      wait_c(2*Q - Q/2 - 1);
    end else wait_c(2*Q);
    scl_drv = 1'b0; wait_c(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, input string req);
    bit a, ea;
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == gbit);
    sda_drv = 1'b1; wait_c(Q);
    scl_drv = 1'b1; wait_c(Q);
    a = !sda_line;
    wait_c(Q);
    scl_drv = 1'b0; wait_c(Q);
    if (mdl_idx == 0) mdl_match = (b == 8'hD2);
    ea = mdl_match;
    if (mdl_match && mdl_idx >= 3 && mdl_idx <= 5) exp_reg[mdl_idx-3] = b;
    if (mdl_idx < 6) mdl_idx++;
    chk(a == ea, req, "ack", 32'(a), 32'(ea));
  endtask

  task automatic chk_enables(input string req);
    hold_src = 1'b1; wait_c(3);
    chk(fan_o == exp_en(), req, "enable map", 32'(fan_o), 32'(exp_en()));
    hold_src = 1'b0; wait_c(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run hung act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) exp_reg[k] = 8'hFF;
    wait_c(5);
    rst_n = 1'b1;
    wait_c(5);
    cmp_on = 1'b1;
    // R1: reset state
    chk(fan_drive == '1, "R1", "reset drive", 32'(fan_drive), 32'h3FFFF);
    chk_enables("R1");

    // R3 R4: full frame, header discarded, data in order
    bus_start();
    send_byte(8'hD2, -1, "R2");
    send_byte(8'h00, -1, "R3");
    send_byte(8'h12, -1, "R3");
    send_byte(8'hA5, -1, "R4");
    send_byte(8'h3C, -1, "R4");
    send_byte(8'h7F, -1, "R4");
    bus_stop();
    chk_enables("R4");
    wait_c(40);

    // R2: wrong address, then read request
    bus_start();
    send_byte(8'hA2, -1, "R2");
    send_byte(8'h00, -1, "R2");
    send_byte(8'h00, -1, "R2");
    send_byte(8'h00, -1, "R2");
    bus_stop();
    chk_enables("R2");
    bus_start();
    send_byte(8'hD3, -1, "R2");
    send_byte(8'h11, -1, "R2");
    send_byte(8'h22, -1, "R2");
    send_byte(8'h00, -1, "R2");
    bus_stop();
    chk_enables("R2");

    // R8: frame cut short after data byte 0
    bus_start();
    send_byte(8'hD2, -1, "R2");
    send_byte(8'hFF, -1, "R3");
    send_byte(8'hFF, -1, "R3");
    send_byte(8'h0F, -1, "R8");
    bus_stop();
    chk_enables("R8");

    // R7: trailing bytes discarded
    bus_start();
    send_byte(8'hD2, -1, "R2");
    send_byte(8'h01, -1, "R3");
    send_byte(8'h03, -1, "R3");
    send_byte(8'hF0, -1, "R4");
    send_byte(8'h99, -1, "R4");
    send_byte(8'h80, -1, "R4");
    send_byte(8'h00, -1, "R7");
    send_byte(8'h00, -1, "R7");
    bus_stop();
    chk_enables("R7");

    // R9: START in mid-frame restarts at the address byte
    bus_start();
    send_byte(8'hD2, -1, "R2");
    send_byte(8'h00, -1, "R3");
    bus_start();
    send_byte(8'h77, -1, "R9");
    send_byte(8'h55, -1, "R9");
    bus_start();
    send_byte(8'hD2, -1, "R9");
    send_byte(8'h00, -1, "R3");
    send_byte(8'h00, -1, "R3");
    send_byte(8'h00, -1, "R9");
    bus_stop();
    chk_enables("R9");

    // R10: one-cycle SDA glitch while SCL high
    bus_start();
    send_byte(8'hD2, -1, "R2");
    send_byte(8'h00, -1, "R3");
    send_byte(8'h00, -1, "R3");
    send_byte(8'hC3, 7, "R10");
    send_byte(8'h5A, 1, "R10");
    send_byte(8'h40, 6, "R10");
    bus_stop();
    chk_enables("R10");

    // R6: global enable low
    out_en = 1'b0;
    wait_c(30);
    chk(fan_drive == '0, "R6", "drive off", 32'(fan_drive), 32'd0);
    chk(fan_o == '0, "R6", "outputs low", 32'(fan_o), 32'd0);
    out_en = 1'b1;
    wait_c(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule